// File: doc/BRIEF.md
# Multi-bank chip-select and wait-state unit

This block sits beside a 32-bit system bus and turns each bus transfer into a select for one of eight memory banks. Every bank holds a descriptor with the following fields: a valid flag, a base address, a power-of-two block size, a port width, a wait-state count and an access-type qualifier. When a master pulses the transfer start, the block compares the address and the type tag against all eight descriptors. It then selects the lowest-numbered bank that matches. For that bank it drives the chip select, the output enable on reads and the byte enables. After the bank's wait states have passed, it returns a one-clock transfer acknowledge.

Software loads descriptors through a single write port, one whole descriptor per write. Bank 0 is the boot bank. Reset leaves it enabled over the top 256 MB of the map with the slowest timing, so a processor can fetch its first instructions before any register has been written.

Top module: `bank_select_unit`

## Requirements
- R1: After reset all outputs are low, banks 1 to 7 are disabled, and bank 0 is valid with base 0xF000_0000, size code 13, port width code 2 (32-bit), 30 wait states and a zero type mask.
- R2: A clock with `cfg_we` high replaces the descriptor of bank `cfg_bank` with `cfg_data`. The layout of `cfg_data` is: [34] valid, [33:17] base address bits 31..15, [16:13] size code, [12:11] width code, [10:6] wait count, [5:3] type mask, [2:0] type value. A bank whose valid bit is 0 never matches.
- R3: Size code s gives a block of 32 KB << s. The address matches when address bits 31..(15+s) equal the same bits of the base, and lower base bits are ignored. Codes 14 and 15 act as 13, which is 256 MB.
- R4: A bank matches only if `(acc_type ^ type value) & type mask` is zero.
- R5: When several banks match, the lowest-numbered bank is used. When none matches, a start produces no chip select, no output enable, no byte enable and no acknowledge.
- R6: From the cycle after an accepted start until the acknowledge cycle ends, `cs` is one-hot on the selected bank. `oe` is high throughout if `rd` was high at the start.
- R7: With wait count W, `ta` is high for exactly one cycle, namely the cycle following the (W+1)-th rising edge after the start edge. All outputs are low in the cycle after it. A count of 31 is treated as 30.
- R8: Width codes 0, 1 and 2 or 3 give 1-, 2- and 4-byte ports. `siz` codes 0, 1 and 2 or 3 request 1, 2 and 4 bytes. The lane count n is the smaller of the request and the port, and the start lane is the address modulo the port bytes. `be` is n ones shifted left by the start lane, truncated to 4 bits, and bit i is lane i.
- R9: A start while an access is active or acknowledging is ignored. A descriptor write during an access does not alter that access's chip select, byte enables or timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_bank | input | 3 | Bank written |
| cfg_data | input | 35 | Descriptor value |
| ts | input | 1 | Transfer start |
| addr | input | 32 | Transfer address |
| acc_type | input | 3 | Access-type tag |
| rd | input | 1 | 1 for read |
| siz | input | 2 | Requested transfer size |
| cs | output | 8 | Bank chip selects |
| oe | output | 1 | Output enable |
| be | output | 4 | Byte-lane enables |
| ta | output | 1 | Transfer acknowledge |

## Verification
Directed accesses are placed so that a single rule decides each outcome. They hit addresses one byte inside and one byte outside a 32 KB block, and they stack a 256 MB bank over a smaller one to show that the lower index wins. They present a type tag that differs only in a masked bit and then only in an unmasked bit. Byte offsets are varied on each port width to separate lane shifting from lane counting. One access is disturbed by a second start and by a descriptor rewrite, which separates timing latched at the start from timing read live. Random descriptors and addresses, reprogrammed periodically, then mix overlaps, size codes above 13 and wait counts up to 31.

// File: rtl/bank_select_unit.sv
module bank_select_unit #(
  parameter int NBANK   = 8,
  parameter int AW      = 32,
  parameter int MINSH   = 15,
  parameter int MAXCODE = 13,
  parameter int WSMAX   = 30,
  parameter int TW      = 3,
  localparam int BKW    = $clog2(NBANK),
  localparam int BW     = AW - MINSH,
  localparam int SZW    = $clog2(MAXCODE + 1),
  localparam int WSW    = $clog2(WSMAX + 1),
  localparam int CW     = 1 + BW + SZW + 2 + WSW + 2 * TW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [BKW-1:0] cfg_bank,
  input  logic [CW-1:0]  cfg_data,
  input  logic           ts,
  input  logic [AW-1:0]  addr,
  input  logic [TW-1:0]  acc_type,
  input  logic           rd,
  input  logic [1:0]     siz,
  output logic [NBANK-1:0] cs,
  output logic           oe,
  output logic [3:0]     be,
  output logic           ta
);
  localparam int TV_LO = 0;
  localparam int TM_LO = TW;
  localparam int WT_LO = 2 * TW;
  localparam int WD_LO = WT_LO + WSW;
  localparam int SZ_LO = WD_LO + 2;
  localparam int BS_LO = SZ_LO + SZW;
  localparam int VLD   = BS_LO + BW;
  localparam logic [BW-1:0]  BOOT_BASE = {BW{1'b1}} << MAXCODE;
  localparam logic [CW-1:0]  BOOT = {1'b1, BOOT_BASE, SZW'(MAXCODE), 2'd2,
                                     WSW'(WSMAX), {TW{1'b0}}, {TW{1'b0}}};

  logic [CW-1:0]    desc [NBANK];
  logic [NBANK-1:0] match;
  logic             hit;
  logic [BKW-1:0]   hit_idx;
  logic [CW-1:0]    hd;
  logic [WSW-1:0]   hwt, wt_c;
  logic [1:0]       pw_l, sz_l, nb_l, lane;
  logic [3:0]       ones, be_n;

  logic             act, ack;
  logic [WSW-1:0]   cnt;
  logic [BKW-1:0]   sel_idx;
  logic             sel_rd;
  logic [3:0]       sel_be;
  logic             busy;

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    logic [SZW-1:0] sc, sce;
    logic [BW-1:0]  amask;
    assign sc    = desc[i][SZ_LO +: SZW];
    assign sce   = (sc > SZW'(MAXCODE)) ? SZW'(MAXCODE) : sc;
    assign amask = {BW{1'b1}} << sce;
    assign match[i] = desc[i][VLD]
                    && (((addr[AW-1:MINSH] ^ desc[i][BS_LO +: BW]) & amask) == '0)
                    && (((acc_type ^ desc[i][TV_LO +: TW]) & desc[i][TM_LO +: TW]) == '0);
  end

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int i = NBANK - 1; i >= 0; i--)
      if (match[i]) begin
        hit = 1'b1;
        hit_idx = BKW'(i);
      end
  end

  assign hd   = desc[hit_idx];
  assign hwt  = hd[WT_LO +: WSW];
  assign wt_c = (hwt > WSW'(WSMAX)) ? WSW'(WSMAX) : hwt;

  always_comb begin
    pw_l = (hd[WD_LO +: 2] == 2'd0) ? 2'd0 : (hd[WD_LO +: 2] == 2'd1) ? 2'd1 : 2'd2;
    sz_l = (siz == 2'd3) ? 2'd2 : siz;
    nb_l = (sz_l < pw_l) ? sz_l : pw_l;
    lane = addr[1:0] & ~(2'b11 << pw_l);
    ones = (nb_l == 2'd0) ? 4'b0001 : (nb_l == 2'd1) ? 4'b0011 : 4'b1111;
    be_n = ones << lane;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBANK; i++) desc[i] <= (i == 0) ? BOOT : '0;
      act <= 1'b0;
      ack <= 1'b0;
      cnt <= '0;
      sel_idx <= '0;
      sel_rd <= 1'b0;
      sel_be <= '0;
    end else begin
      if (cfg_we) desc[cfg_bank] <= cfg_data;
      if (ack) ack <= 1'b0;
      else if (act) begin
        if (cnt == '0) begin
          act <= 1'b0;
          ack <= 1'b1;
        end else cnt <= cnt - 1'b1;
      end else if (ts && hit) begin
        act <= 1'b1;
        cnt <= wt_c;
        sel_idx <= hit_idx;
        sel_rd <= rd;
        sel_be <= be_n;
      end
    end
  end

  assign busy = act | ack;
  assign cs   = {NBANK{busy}} & (NBANK'(1) << sel_idx);
  assign oe   = busy & sel_rd;
  assign be   = {4{busy}} & sel_be;
  assign ta   = ack;

  p_cs_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cs));
  p_oe_in_cs_r6: assert property (@(posedge clk) disable iff (!rst_n) oe |-> (cs != '0));
  p_ta_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n) ta |=> (!ta && cs == '0));
  p_ta_in_cs_r7: assert property (@(posedge clk) disable iff (!rst_n) ta |-> (cs != '0));
  p_wait_bound_r7: assert property (@(posedge clk) disable iff (!rst_n) cnt <= WSW'(WSMAX));
  p_nomatch_r5: assert property (@(posedge clk) disable iff (!rst_n)
                                 (!busy && ts && !hit) |=> (cs == '0));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
                              act |=> ($stable(cs) && $stable(be) && $stable(oe)));
endmodule

// File: tb/test_bank_select_unit.sv
module test_bank_select_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_bank = '0;
  logic [34:0] cfg_data = '0;
  logic        ts = 1'b0;
  logic [31:0] addr = '0;
  logic [2:0]  acc_type = '0;
  logic        rd = 1'b0;
  logic [1:0]  siz = '0;
  logic [7:0]  cs;
  logic        oe;
  logic [3:0]  be;
  logic        ta;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;
  logic [34:0] mdesc [8];

  always #4 clk = ~clk;

  bank_select_unit i_bank_select_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_data(cfg_data),
    .ts(ts), .addr(addr), .acc_type(acc_type), .rd(rd), .siz(siz),
    .cs(cs), .oe(oe), .be(be), .ta(ta));

  function automatic logic [34:0] pack(input bit v, input logic [31:0] b, input int s,
                                        input int w, input int wt, input int tm, input int tv);
    return {v, b[31:15], 4'(s), 2'(w), 5'(wt), 3'(tm), 3'(tv)};
  endfunction

  function automatic bit m_match(input logic [34:0] d, input logic [31:0] a, input logic [2:0] t);
    int s = int'(d[16:13]);
    logic [16:0] m;
    if (s > 13) s = 13;
    m = 17'h1FFFF << s;
    return d[34] && (((a[31:15] ^ d[33:17]) & m) == 0) && (((t ^ d[2:0]) & d[5:3]) == 0);
  endfunction

  function automatic int m_hit(input logic [31:0] a, input logic [2:0] t);
    for (int i = 0; i < 8; i++) if (m_match(mdesc[i], a, t)) return i;
    return -1;
  endfunction

  function automatic logic [3:0] m_be(input logic [34:0] d, input logic [31:0] a, input logic [1:0] s);
    int pb = (d[12:11] == 0) ? 1 : (d[12:11] == 1) ? 2 : 4;
    int rb = (s == 0) ? 1 : (s == 1) ? 2 : 4;
    int n = (rb < pb) ? rb : pb;
    int ln = int'(a[1:0]) % pb;
    logic [7:0] v = 8'((1 << n) - 1) << ln;
    return v[3:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wcfg(input int b, input logic [34:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = 3'(b); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    mdesc[b] = d;
  endtask

  task automatic access(input logic [31:0] a, input logic [2:0] t, input logic r,
                        input logic [1:0] s, input bit disturb, input string tag);
    int k = m_hit(a, t);
    int w, first;
    bit held;
    logic [7:0] ecs;
    logic [3:0] ebe;
    logic [34:0] nd;
    @(negedge clk);
    ts = 1'b1; addr = a; acc_type = t; rd = r; siz = s;
    @(negedge clk);
    ts = 1'b0;
    if (k < 0) begin
      held = 1;
      for (int j = 0; j < 4; j++) begin
        if (j > 0) @(negedge clk);
        if (cs != 0 || oe || be != 0 || ta) held = 0;
      end
      chk(held, {tag, " R5 no-match silent"}, {cs, be, 3'b0, ta}, 0);
      return;
    end
    w = int'(mdesc[k][10:6]);
    if (w > 30) w = 30;
    ecs = 8'(1 << k);
    ebe = m_be(mdesc[k], a, s);
    chk({cs, oe, be} == {ecs, r, ebe}, {tag, " R6/R8 selects"}, {cs, 3'b0, oe, be}, {ecs, 3'b0, r, ebe});
    first = -1; held = 1;
    nd = mdesc[k];
    for (int j = 0; j < 40 && first < 0; j++) begin
      if (j > 0) @(negedge clk);
      if (cs != ecs || be != ebe || oe != r) held = 0;
      if (ta) first = j;
      if (disturb && j == 1) begin
        ts = 1'b1; addr = 32'hF000_0000; acc_type = 0;
        nd = mdesc[k]; nd[10:6] = 5'd1; nd[12:11] = 2'd0;
        cfg_we = 1'b1; cfg_bank = 3'(k); cfg_data = nd;
      end
      if (disturb && j == 2) begin
        ts = 1'b0; cfg_we = 1'b0;
        mdesc[k] = nd;
      end
    end
    chk(first == w + 1, {tag, " R7 ack cycle"}, first, w + 1);
    chk(held, {tag, " R6/R9 held"}, {cs, be}, {ecs, ebe});
    @(negedge clk);
    chk(cs == 0 && !ta && !oe && be == 0, {tag, " R7 release"}, {cs, be, 3'b0, ta}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) mdesc[i] = '0;
    mdesc[0] = pack(1, 32'hF000_0000, 13, 2, 30, 0, 0);
    repeat (3) @(negedge clk);
    chk(cs == 0 && !oe && be == 0 && !ta, "R1 reset outputs", {cs, be, 3'b0, ta}, 0);
    rst_n = 1'b1;
    access(32'hF123_4560, 3'd6, 1, 2'd2, 0, "R1 boot read");
    access(32'hEFFF_FFFC, 3'd0, 1, 2'd2, 0, "R1 below boot");
    access(32'h0000_1000, 3'd0, 0, 2'd2, 0, "R5 empty map");
    wcfg(2, pack(1, 32'h0000_8000, 0, 0, 0, 0, 0));
    access(32'h0000_8003, 3'd2, 1, 2'd1, 0, "R3/R8 byte port");
    access(32'h0001_0000, 3'd2, 1, 2'd1, 0, "R3 above block");
    access(32'h0000_7FFF, 3'd2, 1, 2'd0, 0, "R3 below block");
    wcfg(1, pack(1, 32'h0000_0000, 13, 1, 31, 0, 0));
    access(32'h0000_8002, 3'd0, 0, 2'd2, 0, "R5/R7 priority clamp");
    access(32'h0000_8001, 3'd0, 1, 2'd0, 0, "R8 16-bit odd byte");
    wcfg(3, pack(1, 32'h4000_0000, 4, 2, 2, 6, 4));
    access(32'h4007_FFF0, 3'd5, 1, 2'd2, 0, "R4 masked bit differs");
    access(32'h4007_FFF0, 3'd1, 1, 2'd2, 0, "R4 unmasked bit differs");
    access(32'h4000_0002, 3'd4, 0, 2'd0, 0, "R8 32-bit byte lane2");
    access(32'h4000_0002, 3'd4, 0, 2'd1, 0, "R8 32-bit half lane2");
    wcfg(4, pack(1, 32'h2000_0000, 15, 2, 3, 0, 0));
    access(32'h2FFF_FFF0, 3'd0, 1, 2'd2, 0, "R3 code15 top");
    access(32'h3000_0000, 3'd0, 1, 2'd2, 0, "R3 code15 outside");
    wcfg(5, pack(1, 32'h6000_0000, 2, 2, 5, 0, 0));
    access(32'h6000_0010, 3'd0, 1, 2'd2, 1, "R9 disturbed");
    access(32'h6000_0010, 3'd0, 1, 2'd2, 0, "R2 rewritten descriptor");
    wcfg(5, pack(0, 32'h6000_0000, 2, 2, 5, 0, 0));
    access(32'h6000_0010, 3'd0, 1, 2'd2, 0, "R2 invalidated");
    for (int n = 0; n < 300; n++) begin
      logic [31:0] a;
      if (n % 25 == 0)
        for (int b = 1; b < 8; b++)
          wcfg(b, pack(($urandom % 8) != 0, $urandom, $urandom % 16, $urandom % 4,
                       $urandom % 32, $urandom % 8, $urandom % 8));
      if ($urandom % 2 == 1) a = {mdesc[$urandom % 8][33:17], 15'b0} ^ ($urandom & 32'h00FF_FFFF);
      else a = $urandom;
      access(a, 3'($urandom), 1'($urandom), 2'($urandom), 0, "R3/R4/R5/R8 random");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule